// File: doc/BRIEF.md
# Boundary Event Acceptance Gate

This block sits beside an instruction sequencer and picks, at every instruction boundary, the single pending event the processor takes next. Six event sources compete: an internal exception, an I/O protection exception, a debug fault, a non-maskable request, a single-step trap and a maskable request. The interrupt-enable bit gates only the maskable source. The trap bit turns each completed instruction into a single-step request. An internally held resume bit keeps debug faults out until an instruction completes. The block also compares the current privilege level against a 2-bit I/O privilege field whenever the boundary belongs to an I/O instruction. It either grants the access or turns it into a protection exception.

Request pulses that arrive between boundaries, or that lose arbitration, are held in a pending set and compete again at the next boundary. The winner is reported one cycle after the boundary as a one-cycle strobe and a 3-bit code. The resume bit is available as an output so that the surrounding logic can save it.

Top module: `event_accept_gate`

## Requirements
- R1: Out of reset, acceptStb is 0, eventCode is 0, resumeBit is 0 and no event is pending.
- R2: A maskable request is accepted only at a boundary where intEn is 1. While intEn is 0 it is not accepted but stays pending. Its code is 6.
- R3: An internal exception (code 1) and a non-maskable request (code 4) are accepted whatever the value of intEn.
- R4: At a boundary where the instruction completes and trapEn is 1, a single-step request (code 5) is raised.
- R5: A debug fault (code 3) is accepted only at a boundary where resumeBit, as held before that boundary, is 0.
- R6: resumeBit becomes 1 in the cycle after a boundary that accepts code 1 or code 2. Otherwise it becomes 0 in the cycle after a boundary where the instruction completes. Otherwise it holds.
- R7: At a boundary with ioInstr high, access is granted when cpl <= ioPriv (unsigned), giving an ioGrant pulse one cycle later. Otherwise a protection exception (code 2) is raised and the instruction does not count as completed.
- R8: Priority, highest first, is code 1, 2, 3, 4, 5, 6, considering only eligible events.
- R9: At most one event is accepted per boundary. acceptStb is high only in the cycle after a boundary, and eventCode is 0 whenever acceptStb is 0.
- R10: A request that is not accepted, whether it arrived between boundaries or lost arbitration, stays pending until a later boundary accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| boundary | input | 1 | Current cycle is an instruction boundary |
| instrOk | input | 1 | Instruction ending at this boundary finished without fault |
| ioInstr | input | 1 | Instruction at this boundary is an I/O access |
| cpl | input | 2 | Current privilege level |
| ioPriv | input | 2 | I/O privilege field |
| intEn | input | 1 | Interrupt-enable bit |
| trapEn | input | 1 | Trap (single-step) bit |
| excReq | input | 1 | Internal exception request pulse |
| nmiReq | input | 1 | Non-maskable request pulse |
| dbgReq | input | 1 | Debug fault request pulse |
| maskReq | input | 1 | Maskable request pulse |
| acceptStb | output | 1 | One-cycle strobe: an event was accepted |
| eventCode | output | 3 | Code of the accepted event, 0 when none |
| ioGrant | output | 1 | One-cycle pulse: I/O access permitted |
| resumeBit | output | 1 | Resume bit that suppresses debug faults |

## Verification
Every result is registered once. acceptStb, eventCode, ioGrant and the updated resumeBit all appear in the cycle after the boundary whose inputs caused them. The debug-fault eligibility at a boundary uses the resumeBit value from before that boundary. The bench drives inputs on the falling edge, computes its expected outputs right away from its own model of pending events and the resume bit, and compares them on the next falling edge, one rising edge later. Directed sequences cover the full priority ladder, a masked request that waits, and the I/O privilege corners. A seeded random phase covers the rest.

// File: rtl/gate_pkg.sv
package gate_pkg;
  localparam int NUM_EVT = 6;
  localparam int CODE_W  = 3;

  // index order is priority order (0 highest); code = index + 1
  localparam int IDX_EXC  = 0;
  localparam int IDX_PROT = 1;
  localparam int IDX_DBG  = 2;
  localparam int IDX_NMI  = 3;
  localparam int IDX_STEP = 4;
  localparam int IDX_MASK = 5;

  typedef enum logic [CODE_W-1:0] {
    EV_NONE = 3'd0, EV_EXC = 3'd1, EV_PROT = 3'd2, EV_DBG = 3'd3,
    EV_NMI = 3'd4, EV_STEP = 3'd5, EV_MASK = 3'd6
  } evCode_e;

  typedef struct packed {
    logic [NUM_EVT-1:0] grant;
    logic               take;
    logic               rfSet;
    logic               rfClr;
  } ctrlStb_t;
endpackage

// File: rtl/gate_datapath.sv
module gate_datapath
  import gate_pkg::*;
#(
  parameter int PRIV_W = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               boundary,
  input  logic               instrOk,
  input  logic               ioInstr,
  input  logic [PRIV_W-1:0]  cpl,
  input  logic [PRIV_W-1:0]  ioPriv,
  input  logic               trapEn,
  input  logic               excReq,
  input  logic               nmiReq,
  input  logic               dbgReq,
  input  logic               maskReq,
  input  ctrlStb_t           ctrl,
  output logic [NUM_EVT-1:0] effReq,
  output logic               done,
  output logic               rfBit,
  output logic               acceptStb,
  output logic [CODE_W-1:0]  eventCode,
  output logic               ioGrant
);
  logic               ioDenied;
  logic [NUM_EVT-1:0] newReq;
  logic [NUM_EVT-1:0] pend;
  logic [CODE_W-1:0]  codeNext;

  assign ioDenied = ioInstr && (cpl > ioPriv);
  assign done     = boundary && instrOk && !ioDenied;

  always_comb begin
    newReq           = '0;
    newReq[IDX_EXC]  = excReq;
    newReq[IDX_PROT] = boundary && ioDenied;
    newReq[IDX_DBG]  = dbgReq;
    newReq[IDX_NMI]  = nmiReq;
    newReq[IDX_STEP] = done && trapEn;
    newReq[IDX_MASK] = maskReq;
  end

  assign effReq = pend | newReq;

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_pend
    always_ff @(posedge clk) begin
      if (!rstN) pend[i] <= 1'b0;
      else       pend[i] <= effReq[i] & ~ctrl.grant[i];
    end
  end

  always_comb begin
    codeNext = '0;
    for (int i = 0; i < NUM_EVT; i++)
      if (ctrl.grant[i]) codeNext = CODE_W'(i + 1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acceptStb <= 1'b0;
      eventCode <= '0;
      ioGrant   <= 1'b0;
      rfBit     <= 1'b0;
    end else begin
      acceptStb <= ctrl.take;
      eventCode <= codeNext;
      ioGrant   <= boundary && ioInstr && !ioDenied;
      if (ctrl.rfSet)      rfBit <= 1'b1;
      else if (ctrl.rfClr) rfBit <= 1'b0;
    end
  end
endmodule

// File: rtl/gate_control.sv
module gate_control
  import gate_pkg::*;
(
  input  logic [NUM_EVT-1:0] effReq,
  input  logic               boundary,
  input  logic               done,
  input  logic               intEn,
  input  logic               rfBit,
  output ctrlStb_t           ctrl
);
  logic [NUM_EVT-1:0] elig;
  logic [NUM_EVT-1:0] grant;

  always_comb begin
    elig           = effReq;
    elig[IDX_MASK] = effReq[IDX_MASK] && intEn;
    elig[IDX_DBG]  = effReq[IDX_DBG] && !rfBit;
  end

  always_comb begin
    logic found;
    found = 1'b0;
    grant = '0;
    for (int i = 0; i < NUM_EVT; i++) begin
      if (boundary && !found && elig[i]) begin
        grant[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  always_comb begin
    ctrl.grant = grant;
    ctrl.take  = |grant;
    ctrl.rfSet = grant[IDX_EXC] || grant[IDX_PROT];
    ctrl.rfClr = done && !(grant[IDX_EXC] || grant[IDX_PROT]);
  end
endmodule

// File: rtl/event_accept_gate.sv
module event_accept_gate
  import gate_pkg::*;
#(
  parameter int PRIV_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              boundary,
  input  logic              instrOk,
  input  logic              ioInstr,
  input  logic [PRIV_W-1:0] cpl,
  input  logic [PRIV_W-1:0] ioPriv,
  input  logic              intEn,
  input  logic              trapEn,
  input  logic              excReq,
  input  logic              nmiReq,
  input  logic              dbgReq,
  input  logic              maskReq,
  output logic              acceptStb,
  output logic [2:0]        eventCode,
  output logic              ioGrant,
  output logic              resumeBit
);
  ctrlStb_t           ctrl;
  logic [NUM_EVT-1:0] effReq;
  logic               done;

  gate_datapath #(.PRIV_W(PRIV_W)) u_dp (
    .clk(clk), .rstN(rstN), .boundary(boundary), .instrOk(instrOk),
    .ioInstr(ioInstr), .cpl(cpl), .ioPriv(ioPriv), .trapEn(trapEn),
    .excReq(excReq), .nmiReq(nmiReq), .dbgReq(dbgReq), .maskReq(maskReq),
    .ctrl(ctrl), .effReq(effReq), .done(done), .rfBit(resumeBit),
    .acceptStb(acceptStb), .eventCode(eventCode), .ioGrant(ioGrant)
  );

  gate_control u_ctl (
    .effReq(effReq), .boundary(boundary), .done(done), .intEn(intEn),
    .rfBit(resumeBit), .ctrl(ctrl)
  );
endmodule

// File: rtl/gate_checker.sv
module gate_checker #(
  parameter int PRIV_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              boundary,
  input logic              ioInstr,
  input logic [PRIV_W-1:0] cpl,
  input logic [PRIV_W-1:0] ioPriv,
  input logic              intEn,
  input logic              acceptStb,
  input logic [2:0]        eventCode,
  input logic              ioGrant,
  input logic              resumeBit
);
  // R9
  strobe_after_boundary_chk: assert property (@(posedge clk) disable iff (!rstN)
    acceptStb |-> $past(boundary));
  // R9
  code_idle_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !acceptStb |-> eventCode == 3'd0);
  // R8
  code_in_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    acceptStb |-> (eventCode >= 3'd1 && eventCode <= 3'd6));
  // R2
  mask_needs_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (acceptStb && eventCode == 3'd6) |-> $past(intEn));
  // R5
  debug_needs_clear_rf_chk: assert property (@(posedge clk) disable iff (!rstN)
    (acceptStb && eventCode == 3'd3) |-> $past(!resumeBit));
  // R6
  fault_sets_rf_chk: assert property (@(posedge clk) disable iff (!rstN)
    (acceptStb && (eventCode == 3'd1 || eventCode == 3'd2)) |-> resumeBit);
  // R7
  io_grant_privilege_chk: assert property (@(posedge clk) disable iff (!rstN)
    ioGrant |-> $past(boundary && ioInstr && (cpl <= ioPriv)));
endmodule

bind event_accept_gate gate_checker #(.PRIV_W(PRIV_W)) u_chk (
  .clk(clk), .rstN(rstN), .boundary(boundary), .ioInstr(ioInstr),
  .cpl(cpl), .ioPriv(ioPriv), .intEn(intEn), .acceptStb(acceptStb),
  .eventCode(eventCode), .ioGrant(ioGrant), .resumeBit(resumeBit)
);

// File: tb/tb_event_accept_gate.sv
module tb_event_accept_gate;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic boundary = 0, instrOk = 0, ioInstr = 0, intEn = 0, trapEn = 0;
  logic [1:0] cpl = 0, ioPriv = 0;
  logic excReq = 0, nmiReq = 0, dbgReq = 0, maskReq = 0;
  logic acceptStb, ioGrant, resumeBit;
  logic [2:0] eventCode;

  int total = 0, bad = 0;
  bit finished = 0;

  // model state
  logic [5:0] mPend = '0;
  logic       mRf = 1'b0;
  logic       expStb, expIo, expRf;
  logic [2:0] expCode;
  bit         haveExp = 0;

  always #10 clk = ~clk;

  event_accept_gate dut (
    .clk(clk), .rstN(rstN), .boundary(boundary), .instrOk(instrOk),
    .ioInstr(ioInstr), .cpl(cpl), .ioPriv(ioPriv), .intEn(intEn),
    .trapEn(trapEn), .excReq(excReq), .nmiReq(nmiReq), .dbgReq(dbgReq),
    .maskReq(maskReq), .acceptStb(acceptStb), .eventCode(eventCode),
    .ioGrant(ioGrant), .resumeBit(resumeBit)
  );

  function automatic string tagOf(input logic [2:0] c);
    case (c)
      3'd1: return "R3/R8";
      3'd2: return "R7/R8";
      3'd3: return "R5/R8";
      3'd4: return "R3/R8";
      3'd5: return "R4/R8";
      3'd6: return "R2/R8";
      default: return "R9/R10";
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // expected result of the inputs now on the pins (from the requirements)
  task automatic model();
    logic denied, dn;
    logic [5:0] nreq, eff, elig, grant;
    denied  = ioInstr && (cpl > ioPriv);
    dn      = boundary && instrOk && !denied;
    nreq    = {maskReq, dn && trapEn, nmiReq, dbgReq, boundary && denied, excReq};
    eff     = mPend | nreq;
    elig    = eff;
    elig[5] = eff[5] && intEn;
    elig[2] = eff[2] && !mRf;
    grant   = '0;
    expCode = 3'd0;
    if (boundary)
      for (int i = 5; i >= 0; i--)
        if (elig[i]) begin grant = '0; grant[i] = 1'b1; expCode = 3'(i + 1); end
    expStb = |grant;
    expIo  = boundary && ioInstr && !denied;
    mPend  = eff & ~grant;
    if (grant[0] || grant[1]) mRf = 1'b1;
    else if (dn)              mRf = 1'b0;
    expRf  = mRf;
  endtask

  // check the previous cycle's results, then apply the new inputs
  task automatic tick(input logic b, ok, io, input logic [1:0] c, p,
                      input logic ie, tr, ex, nm, db, mk);
    @(negedge clk);
    if (haveExp) begin
      chk(tagOf(expCode), int'(acceptStb), int'(expStb));
      chk(tagOf(expCode), int'(eventCode), int'(expCode));
      chk("R7", int'(ioGrant), int'(expIo));
      chk("R6", int'(resumeBit), int'(expRf));
    end
    boundary = b; instrOk = ok; ioInstr = io; cpl = c; ioPriv = p;
    intEn = ie; trapEn = tr; excReq = ex; nmiReq = nm; dbgReq = db; maskReq = mk;
    model();
    haveExp = 1;
  endtask

  task automatic idleBnd(input logic ok, ie);
    tick(1, ok, 0, 2'd0, 2'd0, ie, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1c3a_5e07));
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", int'(acceptStb), 0);
    chk("R1", int'(eventCode), 0);
    chk("R1", int'(resumeBit), 0);
    chk("R1", int'(ioGrant), 0);

    // R8 full ladder: all sources at one boundary, I/O denied (cpl 2 > priv 1)
    tick(1, 1, 1, 2'd2, 2'd1, 1, 1, 1, 1, 1, 1);
    // instruction not completed, so no step from the denied I/O; loop drains
    for (int k = 0; k < 5; k++) idleBnd(0, 1);   // R5: debug held while rf=1
    idleBnd(1, 1);                                // completion clears rf
    idleBnd(0, 1);                                // debug now accepted
    idleBnd(0, 1);

    // R4 step from a completed instruction with trap set
    tick(1, 1, 0, 2'd0, 2'd0, 1, 1, 0, 0, 0, 0);
    idleBnd(0, 1);

    // R2 masked request waits while intEn=0, then is taken; R10 pending
    tick(0, 0, 0, 2'd0, 2'd0, 0, 0, 0, 0, 0, 1);
    idleBnd(0, 0);
    idleBnd(0, 0);
    // R3 nmi and exception ignore intEn
    tick(1, 0, 0, 2'd0, 2'd0, 0, 0, 0, 1, 0, 0);
    tick(1, 0, 0, 2'd0, 2'd0, 0, 0, 1, 0, 0, 0);
    idleBnd(1, 1);
    idleBnd(1, 1);

    // R7 privilege corners
    tick(1, 1, 1, 2'd3, 2'd3, 0, 0, 0, 0, 0, 0);
    tick(1, 1, 1, 2'd0, 2'd0, 0, 0, 0, 0, 0, 0);
    tick(1, 1, 1, 2'd1, 2'd0, 0, 0, 0, 0, 0, 0);
    tick(1, 1, 1, 2'd0, 2'd3, 0, 0, 0, 0, 0, 0);

    // R10 request between boundaries survives several idle cycles
    tick(0, 0, 0, 2'd0, 2'd0, 1, 0, 0, 0, 1, 0);
    for (int k = 0; k < 3; k++) tick(0, 0, 0, 2'd0, 2'd0, 1, 0, 0, 0, 0, 0);
    idleBnd(0, 1);
    idleBnd(0, 1);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      tick(($urandom % 2) == 0, ($urandom % 4) != 0, ($urandom % 4) == 0,
           2'($urandom), 2'($urandom), ($urandom % 3) != 0, ($urandom % 5) == 0,
           ($urandom % 20) == 0, ($urandom % 20) == 0,
           ($urandom % 8) == 0, ($urandom % 6) == 0);
    end
    tick(0, 0, 0, 2'd0, 2'd0, 0, 0, 0, 0, 0, 0);
    tick(0, 0, 0, 2'd0, 2'd0, 0, 0, 0, 0, 0, 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule